// File: doc/BRIEF.md
# Indirect Flash Write Staging Controller

This block stages host data for an indirect flash write. Software sets a flash start address, a total byte count, a free-space watermark and a host address window, then pulses a start pin. The host then streams its data as 32-bit writes into the window. The block packs the accepted bytes into an internal byte-wide SRAM ring. A downstream byte consumer, which stands in for the flash program engine, drains that ring in arrival order. Each byte carries the flash address it belongs at, beginning with the programmed start address and stepping by one.

The host write port follows valid/ready rules. A write transfers on a cycle where both `h_wvalid` and `h_wready` are high. While a transfer is active, an in-window write that still has bytes owed holds `h_wready` low whenever fewer than four bytes of SRAM are free. Every other write is taken at once. Each taken write gets a one-cycle response on `h_bvalid` one cycle later, and `h_berr` flags a rejected write. The consumer port follows the same rules. `f_valid` stays high while the SRAM holds a byte, and the byte and its address hold still until `f_ready` takes them.

When the last owed byte leaves the SRAM, a done flag rises and stays up until the next start. A cancel pulse empties the SRAM and returns the block to idle. A watermark pulse tells software that draining has opened up room for more data.

Top module: `iwr_stage_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `f_valid`, `wm_irq` and `h_bvalid` are 0 and `h_wready` is 1.
- R2: A `start` pulse while idle latches the address, count and watermark and raises `busy` on the next cycle. Consumed bytes carry `f_addr` values that begin at `cfg_flash_addr` and rise by one per byte.
- R3: An in-window write pushes its bytes least-significant lane first (`h_wdata[7:0]`, then `[15:8]`, and so on), and the consumer receives them in that order.
- R4: A taken write whose address lies outside `cfg_win_lo..cfg_win_hi` (inclusive), or that arrives while idle, gets `h_bvalid`=1 with `h_berr`=1 on the next cycle and pushes no byte.
- R5: `h_wsize` encodes the width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Only as many bytes as the remaining count allows are pushed, and surplus lanes are dropped. In-window writes made after the count is used up are taken with `h_berr`=0 and push nothing.
- R6: While busy, an in-window write that is still owed bytes sees `h_wready`=0 when fewer than 4 SRAM bytes are free. `h_wready` returns once draining frees 4 bytes.
- R7: `f_valid` is 1 exactly when the SRAM holds data. `f_data` and `f_addr` hold steady while `f_valid` is 1 and `f_ready` is 0.
- R8: On the cycle after the last counted byte is consumed, `done` becomes 1 and `busy` becomes 0. `done` then stays 1 until a start or a cancel. A count of zero sets `done` right after start.
- R9: With a non-zero watermark, `wm_irq` pulses for one cycle when SRAM free space rises above the watermark, having been at or below it since start. A watermark of 0 gives no pulse.
- R10: A `cancel` pulse empties the SRAM and clears `busy` and `done` by the next cycle. A later transfer then receives only its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flash_addr | input | FAW | Flash address of the first byte |
| cfg_byte_count | input | CW | Total bytes in the transfer |
| cfg_watermark | input | LW | Free-space watermark, 0 disables |
| cfg_win_lo | input | HAW | Lowest host address in the window |
| cfg_win_hi | input | HAW | Highest host address in the window |
| start | input | 1 | Begin a transfer (ignored while busy) |
| cancel | input | 1 | Abort and flush |
| h_wvalid | input | 1 | Host write valid |
| h_wready | output | 1 | Host write ready |
| h_waddr | input | HAW | Host write address |
| h_wdata | input | 32 | Host write data |
| h_wsize | input | 2 | Write width code |
| h_bvalid | output | 1 | Write response valid |
| h_berr | output | 1 | Write response error |
| f_valid | output | 1 | Byte available to the flash engine |
| f_ready | input | 1 | Flash engine takes the byte |
| f_data | output | 8 | Staged byte |
| f_addr | output | FAW | Flash address of the staged byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed |
| wm_irq | output | 1 | Watermark pulse |

## Verification
A table of transfers varies the byte count, so that the final write carries one, two, three or four useful bytes. The same table varies the final write width, so that a 32-bit final write over a 3-byte remainder shows that surplus lanes are dropped. It also varies the consumer's ready rhythm: always ready, every other cycle, and every third cycle. The slow rhythm on an 80-byte transfer forces the SRAM to fill, which separates correct back-pressure from lost or duplicated bytes. Directed cases then drive out-of-window and idle writes, a fully stalled consumer against a full SRAM, a cancel that is followed by a fresh transfer, a zero count, and a drain that crosses a watermark and one that runs with the watermark at zero.

// File: rtl/iwr_pkg.sv
package iwr_pkg;
  typedef enum logic [1:0] {
    WSZ_BYTE = 2'd0,
    WSZ_HALF = 2'd1,
    WSZ_WORD = 2'd2,
    WSZ_WIDE = 2'd3
  } wsize_e;

  // Number of byte lanes a write of the given width code carries.
  function automatic logic [2:0] lanes_of(input logic [1:0] code);
    case (wsize_e'(code))
      WSZ_BYTE: lanes_of = 3'd1;
      WSZ_HALF: lanes_of = 3'd2;
      default:  lanes_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/iwr_win_decode.sv
module iwr_win_decode
  import iwr_pkg::*;
#(
  parameter int HAW = 16,
  parameter int CW  = 16
) (
  input  logic [HAW-1:0] addr,
  input  logic [HAW-1:0] win_lo,
  input  logic [HAW-1:0] win_hi,
  input  logic [1:0]     size,
  input  logic [CW-1:0]  left,
  output logic           hit,
  output logic [2:0]     take
);
  logic [2:0] lanes;

  assign hit   = (addr >= win_lo) && (addr <= win_hi);
  assign lanes = lanes_of(size);
  // Clip the lane count to what the transfer still owes.
  assign take  = (left < CW'(lanes)) ? left[2:0] : lanes;
endmodule

// File: rtl/iwr_byte_fifo.sv
module iwr_byte_fifo #(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [2:0]    push_cnt,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [7:0]    rd_data,
  output logic [LW-1:0] fill
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  // Lane i lands i places after the write pointer; lane 0 is consumed first.
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < push_cnt) mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_cnt);
      rd_ptr <= rd_ptr + AW'(pop);
      fill   <= fill + LW'(push_cnt) - LW'(pop);
    end
  end

  assign rd_data = mem[rd_ptr];

  // R6: the host side never pushes past capacity.
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_cnt != 3'd0) |-> (32'(fill) + 32'(push_cnt) <= DEPTH));
  // R7: the consumer only takes bytes that exist.
  a_r7_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill != '0));
endmodule

// File: rtl/iwr_xfer_ctrl.sv
module iwr_xfer_ctrl #(
  parameter  int DEPTH = 32,
  parameter  int CW    = 16,
  parameter  int FAW   = 24,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cancel,
  input  logic [CW-1:0]  cfg_count,
  input  logic [FAW-1:0] cfg_faddr,
  input  logic [LW-1:0]  cfg_wm,
  input  logic           push_en,
  input  logic [2:0]     push_take,
  input  logic           pop,
  input  logic [LW-1:0]  fill,
  output logic           busy,
  output logic           done,
  output logic [CW-1:0]  host_left,
  output logic [FAW-1:0] flash_addr,
  output logic           wm_irq
);
  logic [CW-1:0] drain_left;
  logic [LW-1:0] wm_q;
  logic          above_q;
  logic [LW-1:0] free_bytes;
  logic          above_now;

  assign free_bytes = LW'(DEPTH) - fill;
  assign above_now  = busy && (wm_q != '0) && (free_bytes > wm_q);
  assign wm_irq     = above_now && !above_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      host_left  <= '0;
      drain_left <= '0;
      flash_addr <= '0;
      wm_q       <= '0;
      above_q    <= 1'b0;
    end else if (cancel) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      host_left  <= '0;
      drain_left <= '0;
      above_q    <= 1'b0;
    end else if (start && !busy) begin
      flash_addr <= cfg_faddr;
      host_left  <= cfg_count;
      drain_left <= cfg_count;
      wm_q       <= cfg_wm;
      above_q    <= 1'b1;  // an empty buffer at start is not a rise
      busy       <= (cfg_count != '0);
      done       <= (cfg_count == '0);
    end else begin
      if (push_en) host_left <= host_left - CW'(push_take);
      if (pop) begin
        flash_addr <= flash_addr + FAW'(1);
        drain_left <= drain_left - CW'(1);
        if (drain_left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      above_q <= above_now;
    end
  end

  // R8: completion and activity exclude each other.
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: the watermark signal is a single-cycle pulse.
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wm_irq |=> !wm_irq);
  // R10: cancel always lands in idle.
  a_r10_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!busy && !done));
  // R5: every counted push shrinks what the host still owes.
  a_r5_left_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !cancel) |=> (host_left < $past(host_left)));
endmodule

// File: rtl/iwr_stage_ctrl.sv
module iwr_stage_ctrl #(
  parameter  int DEPTH = 32,
  parameter  int CW    = 16,
  parameter  int FAW   = 24,
  parameter  int HAW   = 16,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FAW-1:0] cfg_flash_addr,
  input  logic [CW-1:0]  cfg_byte_count,
  input  logic [LW-1:0]  cfg_watermark,
  input  logic [HAW-1:0] cfg_win_lo,
  input  logic [HAW-1:0] cfg_win_hi,
  input  logic           start,
  input  logic           cancel,
  input  logic           h_wvalid,
  output logic           h_wready,
  input  logic [HAW-1:0] h_waddr,
  input  logic [31:0]    h_wdata,
  input  logic [1:0]     h_wsize,
  output logic           h_bvalid,
  output logic           h_berr,
  output logic           f_valid,
  input  logic           f_ready,
  output logic [7:0]     f_data,
  output logic [FAW-1:0] f_addr,
  output logic           busy,
  output logic           done,
  output logic           wm_irq
);
  logic          hit;
  logic [2:0]    take;
  logic [CW-1:0] host_left;
  logic [LW-1:0] fill;
  logic          owed;
  logic          room;
  logic          acc;
  logic          push_en;
  logic [2:0]    push_cnt;
  logic          pop;

  iwr_win_decode #(.HAW(HAW), .CW(CW)) u_dec (
    .addr   (h_waddr),
    .win_lo (cfg_win_lo),
    .win_hi (cfg_win_hi),
    .size   (h_wsize),
    .left   (host_left),
    .hit    (hit),
    .take   (take)
  );

  assign owed     = busy && hit && (host_left != '0);
  assign room     = fill <= LW'(DEPTH - 4);
  assign h_wready = !owed || room;
  assign acc      = h_wvalid && h_wready;
  assign push_en  = acc && owed;
  assign push_cnt = push_en ? take : 3'd0;
  assign f_valid  = (fill != '0);
  assign pop      = f_valid && f_ready;

  iwr_byte_fifo #(.DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cancel),
    .push_cnt  (push_cnt),
    .push_data (h_wdata),
    .pop       (pop),
    .rd_data   (f_data),
    .fill      (fill)
  );

  iwr_xfer_ctrl #(.DEPTH(DEPTH), .CW(CW), .FAW(FAW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cancel     (cancel),
    .cfg_count  (cfg_byte_count),
    .cfg_faddr  (cfg_flash_addr),
    .cfg_wm     (cfg_watermark),
    .push_en    (push_en),
    .push_take  (take),
    .pop        (pop),
    .fill       (fill),
    .busy       (busy),
    .done       (done),
    .host_left  (host_left),
    .flash_addr (f_addr),
    .wm_irq     (wm_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_bvalid <= 1'b0;
      h_berr   <= 1'b0;
    end else begin
      h_bvalid <= acc;
      h_berr   <= acc && !(busy && hit);
    end
  end

  // R4: a taken write outside the window or while idle is answered with an error.
  a_r4_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(busy && hit)) |=> (h_bvalid && h_berr));
  // R7: a stalled byte and its address hold still.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && !f_ready && !cancel) |=> (f_valid && $stable(f_data) && $stable(f_addr)));
  // R2: consumed bytes advance the flash address by one.
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !cancel) |=> (f_addr == $past(f_addr) + FAW'(1)));
endmodule

// File: tb/tb_iwr_stage_ctrl.sv
module tb_iwr_stage_ctrl;
  localparam int DEPTH = 32;
  localparam int CW    = 16;
  localparam int FAW   = 24;
  localparam int HAW   = 16;
  localparam int LW    = $clog2(DEPTH) + 1;
  localparam logic [HAW-1:0] WLO = 16'h1000;
  localparam logic [HAW-1:0] WHI = 16'h13FC;

  typedef struct packed {
    logic [15:0] count;
    logic [1:0]  last_sz;
    logic [1:0]  rdy_mode;
    logic [31:0] seed;
    logic [23:0] faddr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'd8,  2'd2, 2'd0, 32'h03020100, 24'h000100},
    '{16'd7,  2'd2, 2'd1, 32'hA0B1C2D3, 24'h00FFFE},
    '{16'd5,  2'd0, 2'd0, 32'h11223344, 24'h123400},
    '{16'd6,  2'd1, 2'd1, 32'h5A6B7C8D, 24'h000010},
    '{16'd80, 2'd2, 2'd2, 32'h01234567, 24'h400000},
    '{16'd1,  2'd0, 2'd2, 32'hFFEEDDCC, 24'h000003}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FAW-1:0] cfg_flash_addr = '0;
  logic [CW-1:0]  cfg_byte_count = '0;
  logic [LW-1:0]  cfg_watermark = '0;
  logic [HAW-1:0] cfg_win_lo = WLO;
  logic [HAW-1:0] cfg_win_hi = WHI;
  logic start = 1'b0;
  logic cancel = 1'b0;
  logic h_wvalid = 1'b0;
  logic h_wready;
  logic [HAW-1:0] h_waddr = '0;
  logic [31:0] h_wdata = '0;
  logic [1:0] h_wsize = 2'd2;
  logic h_bvalid, h_berr;
  logic f_valid;
  logic f_ready = 1'b0;
  logic [7:0] f_data;
  logic [FAW-1:0] f_addr;
  logic busy, done, wm_irq;

  iwr_stage_ctrl #(.DEPTH(DEPTH), .CW(CW), .FAW(FAW), .HAW(HAW)) dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_got = 0;
  int wm_cnt = 0;
  bit cons_en = 1'b0;
  int cons_mode = 0;
  logic [7:0]     got_d [128];
  logic [FAW-1:0] got_a [128];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Consumer rhythm driver.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      f_ready = cons_en && ((cons_mode == 0) || (cons_mode == 1 && cyc % 2 == 0) ||
                            (cons_mode == 2 && cyc % 3 == 0));
    end
  end

  // Monitor, sampling mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (f_valid && f_ready && n_got < 128) begin
        got_d[n_got] = f_data;
        got_a[n_got] = f_addr;
        n_got++;
      end
      if (wm_irq) wm_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic hwrite(input logic [HAW-1:0] a, input logic [31:0] d,
                        input logic [1:0] s, output logic berr);
    @(negedge clk);
    h_wvalid = 1'b1; h_waddr = a; h_wdata = d; h_wsize = s;
    #1;
    while (!h_wready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    berr = h_berr;
    chk("R4 response valid", 32'(h_bvalid), 32'd1);
    h_wvalid = 1'b0;
  endtask

  task automatic go(input logic [FAW-1:0] fa, input logic [CW-1:0] cnt, input logic [LW-1:0] wm);
    @(negedge clk);
    cfg_flash_addr = fa; cfg_byte_count = cnt; cfg_watermark = wm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_got = 0;
    wm_cnt = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    #3;
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] seed, input int k);
    logic [31:0] w;
    w = seed + 32'(k / 4) * 32'h11111111;
    return w[8*(k%4) +: 8];
  endfunction

  initial begin
    logic e;
    int bad_d, bad_a;
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 f_valid", 32'(f_valid), 0);
    chk("R1 wm_irq", 32'(wm_irq), 0);
    chk("R1 h_bvalid", 32'(h_bvalid), 0);
    chk("R1 h_wready", 32'(h_wready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: write while idle is rejected
    hwrite(WLO, 32'hDEADBEEF, 2'd2, e);
    chk("R4 idle write error", 32'(e), 1);

    // Table of transfers (R2, R3, R5, R6, R7, R8)
    for (int v = 0; v < NV; v++) begin
      int nw;
      cons_en = 1'b0;
      go(VEC[v].faddr, VEC[v].count, '0);
      chk("R2 busy after start", 32'(busy), 1);
      cons_mode = int'(VEC[v].rdy_mode);
      cons_en = 1'b1;
      nw = (int'(VEC[v].count) + 3) / 4;
      for (int w = 0; w < nw; w++) begin
        hwrite(WLO + HAW'(4 * w), VEC[v].seed + 32'(w) * 32'h11111111,
               (w == nw - 1) ? VEC[v].last_sz : 2'd2, e);
        if (e) chk("R3 in-window write accepted", 32'(e), 0);
      end
      wait_done();
      chk("R5 byte total", 32'(n_got), 32'(VEC[v].count));
      bad_d = 0; bad_a = 0;
      for (int k = 0; k < int'(VEC[v].count) && k < 128; k++) begin
        if (got_d[k] !== exp_byte(VEC[v].seed, k)) bad_d++;
        if (got_a[k] !== VEC[v].faddr + FAW'(k)) bad_a++;
      end
      chk("R3 byte order and data", 32'(bad_d), 0);
      chk("R2 address sequence", 32'(bad_a), 0);
      chk("R8 done set", 32'(done), 1);
      chk("R8 busy clear", 32'(busy), 0);
    end
    repeat (3) @(negedge clk);
    #2;
    chk("R8 done held", 32'(done), 1);

    // R4 / R3 / R7 / R10: window, lane order, hold, cancel
    cons_en = 1'b0;
    go(24'h000200, 16'd8, '0);
    hwrite(16'h2000, 32'h99887766, 2'd2, e);
    chk("R4 out-of-window error", 32'(e), 1);
    #2;
    chk("R4 nothing pushed", 32'(f_valid), 0);
    hwrite(WLO, 32'h44332211, 2'd2, e);
    chk("R4 in-window okay", 32'(e), 0);
    #2;
    chk("R7 valid with data", 32'(f_valid), 1);
    chk("R3 lane 0 first", 32'(f_data), 32'h11);
    @(negedge clk);
    #2;
    chk("R7 data held", 32'(f_data), 32'h11);
    chk("R7 address held", 32'(f_addr), 32'h200);
    @(negedge clk);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    #2;
    chk("R10 flushed", 32'(f_valid), 0);
    chk("R10 busy clear", 32'(busy), 0);
    chk("R10 done clear", 32'(done), 0);
    go(24'h000500, 16'd4, '0);
    hwrite(WLO, 32'hDDCCBBAA, 2'd2, e);
    cons_mode = 0; cons_en = 1'b1;
    wait_done();
    chk("R10 fresh byte count", 32'(n_got), 4);
    chk("R10 fresh first byte", 32'(got_d[0]), 32'hAA);
    chk("R10 fresh first addr", 32'(got_a[0]), 32'h500);

    // R6 / R9: full SRAM back-pressure, watermark disabled
    cons_en = 1'b0;
    go(24'h001000, 16'd40, '0);
    for (int w = 0; w < 8; w++) hwrite(WLO + HAW'(4 * w), 32'h01010101 * 32'(w), 2'd2, e);
    @(negedge clk);
    h_wvalid = 1'b1; h_waddr = WLO + 16'd32; h_wsize = 2'd2;
    #1;
    chk("R6 ready low when full", 32'(h_wready), 0);
    cons_mode = 0; cons_en = 1'b1;
    @(negedge clk);
    #1;
    chk("R6 ready low below 4 free", 32'(h_wready), 0);
    h_wvalid = 1'b0;
    for (int w = 8; w < 10; w++) hwrite(WLO + HAW'(4 * w), 32'h01010101 * 32'(w), 2'd2, e);
    wait_done();
    chk("R6 all bytes after stall", 32'(n_got), 40);
    chk("R6 last byte", 32'(got_d[39]), 32'h09);
    chk("R9 zero watermark silent", 32'(wm_cnt), 0);

    // R9: watermark crossing
    cons_en = 1'b0;
    go(24'h002000, 16'd16, LW'(20));
    for (int w = 0; w < 4; w++) hwrite(WLO + HAW'(4 * w), 32'hCAFEF00D, 2'd2, e);
    chk("R9 no pulse while filling", 32'(wm_cnt), 0);
    cons_mode = 0; cons_en = 1'b1;
    wait_done();
    chk("R9 one pulse on drain", 32'(wm_cnt), 1);

    // R5: writes after the count is used up
    cons_en = 1'b0;
    go(24'h003000, 16'd2, '0);
    hwrite(WLO, 32'h0000BEEF, 2'd1, e);
    hwrite(WLO + 16'd4, 32'h12345678, 2'd2, e);
    chk("R5 surplus write okay", 32'(e), 0);
    cons_mode = 0; cons_en = 1'b1;
    wait_done();
    chk("R5 surplus pushes nothing", 32'(n_got), 2);
    chk("R5 second byte", 32'(got_d[1]), 32'hBE);

    // R8: zero count
    go(24'h004000, 16'd0, '0);
    #2;
    chk("R8 zero count done", 32'(done), 1);
    chk("R8 zero count idle", 32'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule